// File: doc/BRIEF.md
# Multi-Channel Compare System Timer

This peripheral keeps a free-running up-counter twice the bus width wide (64 bits at the default 32-bit data width) that advances by one on each clock where the tick-enable input is high. The tick is normally a one-cycle pulse every microsecond. Four compare channels each hold a bus-wide compare value. A channel reports a match when the counter's low word equals its compare value on a tick cycle. Software schedules an event by reading the low word, adding a delay, and writing the sum to a compare register.

Each match sets a sticky flag in a shared status register. The flag drives that channel's interrupt line until software clears it by writing a one to its bit. The two counter words are separate read-only registers with no snapshot between them. Software resolves a carry between the two reads by reading the high word a second time.

Register word addresses: 0 = status (channel n at bit n, write ones to clear), 1 = counter low word, 2 = counter high word, 3 + n = compare for channel n.

Top module: `systick_cmp_timer`

## Requirements
- R1: The counter resets to zero. It increments by exactly one on each clock where `tick_en` is high and holds its value on every other clock.
- R2: Word address 0 is status, 1 is the counter low word, 2 is the counter high word, and 3 to 6 are compares 0 to 3. A read of any other address returns zero, and a write to one changes nothing.
- R3: `irq[n]` always equals status bit n.
- R4: Status bit n sets on a clock where `tick_en` is high and the counter low word equals compare n. It stays set until it is cleared.
- R5: A status write with a 1 in bit n clears that bit. A 0 in bit n leaves the bit unchanged.
- R6: If a clear and a match of the same bit fall on the same clock, the bit ends up set.
- R7: The high word increments on the same tick that takes the low word from all ones to zero.
- R8: Writes to the counter words (addresses 1 and 2) have no effect.
- R9: Compare registers reset to zero and read back the value last written. A match on the clock of a compare write uses the value held before that write.
- R10: `bus_rdata` shows the addressed register combinationally while `bus_valid` is high and `bus_write` is low. At all other times it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable, one pulse per tick |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (3) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data |
| irq | output | NUM_CH (4) | Per-channel interrupt lines |

## Verification
The hardest situations to reach are the coincidences. One is a write-one-to-clear on the exact tick where the same channel matches. Another is a compare write on the clock where the old compare value matches. The bench predicts the next tick cycle and the low word from its own model. It idles until that cycle and then issues the access there. A carry into the high word only happens after the low word wraps. The bench therefore runs the timer with a narrow data width so the wrap falls within a few thousand clocks, and it reads both words around the wrap.

// File: rtl/stimer_pkg.sv
package stimer_pkg;
  // word addresses; compare n lives at CMP_BASE + n
  localparam int STAT_ADDR = 0;
  localparam int LO_ADDR   = 1;
  localparam int HI_ADDR   = 2;
  localparam int CMP_BASE  = 3;
endpackage

// File: rtl/stimer_counter.sv
module stimer_counter #(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  output logic [2*DATA_W-1:0]   cnt_o
);
  localparam int CW = 2 * DATA_W;

  logic [CW-1:0] cnt_q;

  // full-width increment; the carry into the upper word falls out naturally
  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return v + CW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= bump(cnt_q);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/stimer_channel.sv
module stimer_channel #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cmp_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt_lo,
  input  logic              clr,
  output logic [DATA_W-1:0] cmp_o,
  output logic              hit_o,
  output logic              flag_o
);
  logic [DATA_W-1:0] cmp_q;
  logic              flag_q;

  // a match beats a same-cycle clear
  function automatic logic flag_next(input logic cur, input logic hit,
                                     input logic clear);
    return hit | (cur & ~clear);
  endfunction

  assign hit_o = tick_en && (cnt_lo == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_we) cmp_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(flag_q, hit_o, clr);
  end

  assign cmp_o  = cmp_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/stimer_rdmux.sv
module stimer_rdmux
  import stimer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 3
) (
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NUM_CH-1:0]        status,
  input  logic [2*DATA_W-1:0]      cnt,
  input  logic [NUM_CH*DATA_W-1:0] cmp_flat,
  output logic [DATA_W-1:0]        rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (int'(addr) == STAT_ADDR)    rdata[NUM_CH-1:0] = status;
      else if (int'(addr) == LO_ADDR) rdata = cnt[DATA_W-1:0];
      else if (int'(addr) == HI_ADDR) rdata = cnt[2*DATA_W-1:DATA_W];
      else begin
        for (int n = 0; n < NUM_CH; n++)
          if (int'(addr) == CMP_BASE + n) rdata = cmp_flat[n*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/systick_cmp_timer.sv
module systick_cmp_timer
  import stimer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = $clog2(NUM_CH + CMP_BASE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int CW = 2 * DATA_W;

  // named internal events, visible to the bound checker
  logic [CW-1:0]            cnt_w;
  logic [NUM_CH-1:0]        hit_vec;
  logic [NUM_CH-1:0]        clr_vec;
  logic [NUM_CH-1:0]        status_vec;
  logic [NUM_CH-1:0]        cmp_we_vec;
  logic [NUM_CH*DATA_W-1:0] cmp_flat;
  logic                     wr_acc;
  logic                     rd_acc;
  logic                     stat_wr;

  assign wr_acc  = bus_valid && bus_write;
  assign rd_acc  = bus_valid && !bus_write;
  assign stat_wr = wr_acc && (int'(bus_addr) == STAT_ADDR);
  assign clr_vec = stat_wr ? bus_wdata[NUM_CH-1:0] : '0;

  stimer_counter #(.DATA_W(DATA_W)) cnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .cnt_o   (cnt_w)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign cmp_we_vec[n] = wr_acc && (int'(bus_addr) == CMP_BASE + n);

    stimer_channel #(.DATA_W(DATA_W)) ch_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .cmp_we  (cmp_we_vec[n]),
      .wdata   (bus_wdata),
      .cnt_lo  (cnt_w[DATA_W-1:0]),
      .clr     (clr_vec[n]),
      .cmp_o   (cmp_flat[n*DATA_W +: DATA_W]),
      .hit_o   (hit_vec[n]),
      .flag_o  (status_vec[n])
    );
  end

  stimer_rdmux #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) rd_i (
    .rd_en    (rd_acc),
    .addr     (bus_addr),
    .status   (status_vec),
    .cnt      (cnt_w),
    .cmp_flat (cmp_flat),
    .rdata    (bus_rdata)
  );

  assign irq = status_vec;
endmodule

// File: rtl/stimer_chk.sv
module stimer_chk #(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick_en,
  input logic                     bus_valid,
  input logic                     bus_write,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic [NUM_CH-1:0]        irq,
  input logic [NUM_CH-1:0]        clr_vec,
  input logic [2*DATA_W-1:0]      cnt,
  input logic [NUM_CH*DATA_W-1:0] cmp_flat
);
  localparam int CW = 2 * DATA_W;

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (cnt == CW'($past(cnt) + CW'(1))));

  // R7
  carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && (&cnt[DATA_W-1:0])) |=>
      (cnt[CW-1:DATA_W] == DATA_W'($past(cnt[CW-1:DATA_W]) + DATA_W'(1))));

  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |-> (bus_rdata == '0));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    // R4
    hit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && (cnt[DATA_W-1:0] == cmp_flat[n*DATA_W +: DATA_W])) |=> irq[n]);

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[n] && !clr_vec[n]) |=> irq[n]);

    // R4
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq[n] && !(tick_en && (cnt[DATA_W-1:0] == cmp_flat[n*DATA_W +: DATA_W])))
        |=> !irq[n]);

    // R5
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[n] && !(tick_en && (cnt[DATA_W-1:0] == cmp_flat[n*DATA_W +: DATA_W])))
        |=> !irq[n]);
  end
endmodule

bind systick_cmp_timer stimer_chk #(
  .DATA_W (DATA_W),
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .clr_vec   (clr_vec),
  .cnt       (cnt_w),
  .cmp_flat  (cmp_flat)
);

// File: tb/systick_cmp_timer_tb.sv
`timescale 1ns/1ps
module systick_cmp_timer_tb_top;
  // narrow words so the low word wraps within a few thousand clocks
  localparam int W   = 10;
  localparam int NCH = 4;
  localparam int AW  = 3;
  localparam int DIV = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          valid = 1'b0;
  logic          write = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic [NCH-1:0] irq;

  int total = 0;
  int bad = 0;
  int phase = 0;
  bit tick_on = 1'b0;

  // reference model state
  logic [2*W-1:0] m_cnt = '0;
  logic [W-1:0]   m_cmp [NCH];
  logic [NCH-1:0] m_st = '0;

  always #2.5 clk = ~clk;

  systick_cmp_timer #(.DATA_W(W), .NUM_CH(NCH), .ADDR_W(AW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick),
    .bus_valid (valid),
    .bus_write (write),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq       (irq)
  );

  function automatic logic [W-1:0] m_lo();
    return m_cnt[W-1:0];
  endfunction

  function automatic logic [W-1:0] m_hi();
    return m_cnt[2*W-1:W];
  endfunction

  function automatic logic [W-1:0] exp_read(input int a);
    logic [W-1:0] r;
    r = '0;
    if (a == 0)      r[NCH-1:0] = m_st;
    else if (a == 1) r = m_lo();
    else if (a == 2) r = m_hi();
    else if (a >= 3 && a < 3 + NCH) r = m_cmp[a-3];
    return r;
  endfunction

  function automatic bit will_tick();
    return tick_on && (phase == 0);
  endfunction

  // behavioural model, one step per rising edge
  always @(posedge clk) begin
    logic [NCH-1:0] hv;
    if (!rst_n) begin
      m_cnt = '0;
      m_st  = '0;
      for (int n = 0; n < NCH; n++) m_cmp[n] = '0;
    end else begin
      for (int n = 0; n < NCH; n++) hv[n] = tick && (m_lo() == m_cmp[n]);
      if (valid && write && addr == 0) m_st = hv | (m_st & ~wdata[NCH-1:0]);
      else                             m_st = m_st | hv;
      if (valid && write && int'(addr) >= 3 && int'(addr) < 3 + NCH)
        m_cmp[int'(addr)-3] = wdata;
      if (tick) m_cnt = m_cnt + 1'b1;
    end
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit v, input bit w, input int a, input logic [W-1:0] d,
                     input string tag);
    @(negedge clk);
    valid = v;
    write = w;
    addr  = AW'(a);
    wdata = d;
    tick  = will_tick();
    phase = (phase + 1) % DIV;
    #1;
    check("R3 irq mirrors status", W'(irq), W'(m_st));
    if (v && !w) check(tag, rdata, exp_read(a));
    else         check("R10 rdata idle", rdata, '0);
  endtask

  task automatic rd(input int a, input string tag);
    cyc(1'b1, 1'b0, a, '0, tag);
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    cyc(1'b1, 1'b1, a, d, "R10 write");
  endtask

  task automatic wait_match(input int ch);
    while (!(will_tick() && m_lo() == m_cmp[ch])) rd(1, "R1 low word");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // reset state, ticks off
    rd(0, "R3 status reset");
    rd(1, "R1 low reset");
    rd(2, "R1 high reset");
    for (int n = 0; n < NCH; n++) rd(3 + n, "R9 compare reset");
    rd(7, "R2 unmapped read");

    // counter words are read-only
    wr(1, 'h155);
    wr(2, 'h0aa);
    rd(1, "R8 low after write");
    rd(2, "R8 high after write");

    // unmapped write
    wr(7, 'h3ff);
    for (int n = 0; n < NCH; n++) rd(3 + n, "R2 compare after unmapped write");
    rd(0, "R2 status after unmapped write");

    // program compares and read them back
    for (int n = 0; n < NCH; n++) wr(3 + n, W'(20 + 5 * n));
    for (int n = 0; n < NCH; n++) rd(3 + n, "R9 compare readback");

    // start ticking; counter advances only on tick cycles
    tick_on = 1'b1;
    for (int i = 0; i < 30; i++) rd(1, "R1 low word");
    for (int i = 0; i < 80; i++) rd(0, "R4 status");

    // clear with a mix of ones and zeros
    wr(0, 'h005);
    rd(0, "R5 partial clear");
    wr(0, 'h000);
    rd(0, "R5 zero write keeps bits");
    wr(0, 'h00f);
    rd(0, "R5 full clear");

    // clear on the same tick as a match
    wr(3, W'(m_lo() + 7));
    wait_match(0);
    wr(0, 'h001);
    rd(0, "R6 match wins over clear");

    // compare rewrite on the matching tick
    wr(0, 'h00f);
    wr(4, W'(m_lo() + 9));
    wait_match(1);
    wr(4, W'(m_lo() + 200));
    rd(0, "R9 old compare still matches");
    rd(4, "R9 new compare stored");

    // run across the low-word wrap
    for (int i = 0; i < 3300; i++) begin
      if (i % 2 == 0) rd(2, "R7 high word");
      else            rd(1, "R1 low word");
    end
    check("R7 high word advanced", m_hi(), W'(1));
    rd(2, "R7 high after wrap");
    rd(0, "R4 status after wrap");

    // stall: counter holds with ticks off
    tick_on = 1'b0;
    for (int i = 0; i < 8; i++) rd(1, "R1 stalled low word");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule